// File: doc/BRIEF.md
# Two-Port GPIO Register Bridge

The bridge sits on a 32-bit word-addressed register bus and holds the registers of two general-purpose I/O ports, called port A and port D. Each port has a data-out register, an output-enable register and a data-in view. A data-in read is not stored state. It is built from the port's data-out value masked by its output enable, with one live device pin merged in at a fixed bit position.

Certain port bits double as side-band pins for two devices. Three bits of the port A data-out register drive the latch and select lines of a NAND flash. The flash ready line comes back on port A data-in bit 7. Port D data-out bit 1 is the clock of a serial temperature sensor, and bit 4 is the host data bit. When software changes the clock bit, the bridge issues a one-cycle edge strobe that carries the new level, so a sensor model or shifter can step once per toggle. The sensor's serial output comes back on port D data-in bit 4.

The remaining word slots inside the 0x5C-byte window are plain read/write storage. Reads return data one cycle after the request.

Top module: `gpio_bridge`

## Requirements
- R1: After reset every register reads 0 except where a live pin is merged in. `flash_addr_latch`, `flash_cmd_latch`, `flash_chip_en`, `sens_clk`, `sens_host_bit` and `sens_edge` are all 0.
- R2: A read request returns `rsp_valid` high with its data exactly one cycle later, and `rsp_valid` is low in every other cycle. A write to a storage slot (any word inside the window other than byte addresses 0x04 and 0x44) is returned unchanged by a later read.
- R3: A read of byte address 0x04 (port A data-in) returns (word 0x00 AND word 0x08), with bit 7 ORed with `flash_ready` sampled in the request cycle.
- R4: One cycle after a write to byte address 0x00 (port A data-out), `flash_addr_latch` equals bit 6 of the written word, `flash_cmd_latch` equals bit 5 and `flash_chip_en` equals bit 4.
- R5: A read of byte address 0x44 (port D data-in) returns (word 0x40 AND word 0x48), with bit 4 ORed with `sens_dout` sampled in the request cycle.
- R6: In the cycle after a write to byte address 0x40 (port D data-out) whose bit 1 differs from the stored bit 1, `sens_edge` is high for exactly one cycle. In that same cycle `sens_clk` shows the new bit 1 and `sens_host_bit` shows the new bit 4. A write that leaves bit 1 unchanged gives no strobe.
- R7: Writes to byte addresses 0x04 and 0x44 are ignored. They change no register, no flash pin and no sensor output, and they cause no strobe.
- R8: Accesses at byte addresses at or above 0x5C, or with address bits [1:0] non-zero, are invalid. Reads of them return 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| flash_ready | input | 1 | Flash ready line |
| flash_addr_latch | output | 1 | Flash address latch enable |
| flash_cmd_latch | output | 1 | Flash command latch enable |
| flash_chip_en | output | 1 | Flash chip enable |
| sens_dout | input | 1 | Sensor serial output |
| sens_clk | output | 1 | Sensor clock level |
| sens_host_bit | output | 1 | Host-to-sensor data bit |
| sens_edge | output | 1 | One-cycle strobe on each sensor clock change |

## Verification
The hardest case to reach is the one where the sensor clock bit is written with its current value while other port D bits change. That write must raise no strobe, yet it does update the host data bit. The stimulus first toggles the clock to set a known level. It then rewrites port D with bit 1 held and bit 4 flipped, and then writes the data-in slot with bit 1 flipped. After each of these writes the bench checks the strobe, the clock level and the host bit against a shadow copy of the registers.

// File: rtl/gpio_bridge_pkg.sv
package gpio_bridge_pkg;
    // word slots whose behaviour differs from plain storage
    localparam int unsigned SLOT_A_OUT = 'h00;
    localparam int unsigned SLOT_A_IN  = 'h01;
    localparam int unsigned SLOT_A_EN  = 'h02;
    localparam int unsigned SLOT_D_OUT = 'h10;
    localparam int unsigned SLOT_D_IN  = 'h11;
    localparam int unsigned SLOT_D_EN  = 'h12;
    // side-band bit positions
    localparam int unsigned BIT_FL_CE   = 4;
    localparam int unsigned BIT_FL_CLE  = 5;
    localparam int unsigned BIT_FL_ALE  = 6;
    localparam int unsigned BIT_FL_RDY  = 7;
    localparam int unsigned BIT_SN_CLK  = 1;
    localparam int unsigned BIT_SN_DATA = 4;
endpackage

// File: rtl/gpio_bridge_decode.sv
module gpio_bridge_decode #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WIN_WORDS = 23,
    localparam int unsigned IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    always_comb begin
        idx = addr[ADDR_W-1:2];
        hit = (addr[1:0] == 2'b00) && (idx < IDX_W'(WIN_WORDS));
    end
endmodule

// File: rtl/gpio_bridge_regs.sv
module gpio_bridge_regs
    import gpio_bridge_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WIN_WORDS = 23,
    parameter int unsigned IDX_W     = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [WIN_WORDS-1:0][DATA_W-1:0]    words
);
    typedef struct packed {
        logic [WIN_WORDS-1:0][DATA_W-1:0] word;
    } rf_t;

    rf_t rf_d, rf_q;
    logic store_ok;

    always_comb begin
        rf_d     = rf_q;
        // data-in slots are views, never storage
        store_ok = wr_en && (wr_idx != IDX_W'(SLOT_A_IN)) && (wr_idx != IDX_W'(SLOT_D_IN));
        for (int i = 0; i < int'(WIN_WORDS); i++) begin
            if (store_ok && (wr_idx == IDX_W'(i))) begin
                rf_d.word[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign words = rf_q.word;
endmodule

// File: rtl/gpio_bridge_readmux.sv
module gpio_bridge_readmux
    import gpio_bridge_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WIN_WORDS = 23,
    parameter int unsigned IDX_W     = 6
) (
    input  logic [WIN_WORDS-1:0][DATA_W-1:0] words,
    input  logic [IDX_W-1:0]                 idx,
    input  logic                             hit,
    input  logic                             fl_ready,
    input  logic                             sn_dout,
    output logic [DATA_W-1:0]                rdata
);
    always_comb begin
        rdata = '0;
        if (hit) begin
            if (idx == IDX_W'(SLOT_A_IN)) begin
                rdata = words[SLOT_A_OUT] & words[SLOT_A_EN];
                rdata[BIT_FL_RDY] = rdata[BIT_FL_RDY] | fl_ready;
            end else if (idx == IDX_W'(SLOT_D_IN)) begin
                rdata = words[SLOT_D_OUT] & words[SLOT_D_EN];
                rdata[BIT_SN_DATA] = rdata[BIT_SN_DATA] | sn_dout;
            end else begin
                for (int i = 0; i < int'(WIN_WORDS); i++) begin
                    if (idx == IDX_W'(i)) begin
                        rdata = words[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bridge.sv
module gpio_bridge
    import gpio_bridge_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WIN_BYTES = 'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              flash_ready,
    output logic              flash_addr_latch,
    output logic              flash_cmd_latch,
    output logic              flash_chip_en,
    input  logic              sens_dout,
    output logic              sens_clk,
    output logic              sens_host_bit,
    output logic              sens_edge
);
    localparam int unsigned WIN_WORDS = WIN_BYTES / 4;
    localparam int unsigned IDX_W     = ADDR_W - 2;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              strobe;
    } rsp_t;

    logic [IDX_W-1:0]                 idx;
    logic                             hit;
    logic [WIN_WORDS-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]                mux_data;
    logic                             wr_ok;
    rsp_t                             st_d, st_q;

    gpio_bridge_decode #(.ADDR_W(ADDR_W), .WIN_WORDS(WIN_WORDS)) u_dec (
        .addr (req_addr),
        .idx  (idx),
        .hit  (hit)
    );

    assign wr_ok = req_valid && req_write && hit;

    gpio_bridge_regs #(.DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .words   (words)
    );

    gpio_bridge_readmux #(.DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS), .IDX_W(IDX_W)) u_rmux (
        .words    (words),
        .idx      (idx),
        .hit      (hit),
        .fl_ready (flash_ready),
        .sn_dout  (sens_dout),
        .rdata    (mux_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req_valid && !req_write;
        st_d.rdata  = (req_valid && !req_write) ? mux_data : '0;
        // strobe lands with the register update that changes the clock bit
        st_d.strobe = wr_ok && (idx == IDX_W'(SLOT_D_OUT))
                      && (req_wdata[BIT_SN_CLK] != words[SLOT_D_OUT][BIT_SN_CLK]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid        = st_q.rvalid;
    assign rsp_rdata        = st_q.rdata;
    assign sens_edge        = st_q.strobe;
    assign flash_addr_latch = words[SLOT_A_OUT][BIT_FL_ALE];
    assign flash_cmd_latch  = words[SLOT_A_OUT][BIT_FL_CLE];
    assign flash_chip_en    = words[SLOT_A_OUT][BIT_FL_CE];
    assign sens_clk         = words[SLOT_D_OUT][BIT_SN_CLK];
    assign sens_host_bit    = words[SLOT_D_OUT][BIT_SN_DATA];
endmodule

// File: rtl/gpio_bridge_chk.sv
module gpio_bridge_chk
    import gpio_bridge_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WIN_BYTES = 'h5C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              flash_ready,
    input logic              flash_addr_latch,
    input logic              flash_cmd_latch,
    input logic              flash_chip_en,
    input logic              sens_dout,
    input logic              sens_clk,
    input logic              sens_edge
);
    logic rd_req, wr_req;
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    // R2: read response timing
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    // R3: ready pin visible on port A data-in
    p_ready_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == ADDR_W'(SLOT_A_IN * 4) && flash_ready) |=> rsp_rdata[BIT_FL_RDY]);

    // R4: flash pins follow port A data-out
    p_flash_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_addr == ADDR_W'(SLOT_A_OUT * 4)) |=>
        (flash_addr_latch == $past(req_wdata[BIT_FL_ALE]) &&
         flash_cmd_latch  == $past(req_wdata[BIT_FL_CLE]) &&
         flash_chip_en    == $past(req_wdata[BIT_FL_CE])));

    // R5: sensor output visible on port D data-in
    p_sdo_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == ADDR_W'(SLOT_D_IN * 4) && sens_dout) |=> rsp_rdata[BIT_SN_DATA]);

    // R6: strobe exactly when the clock level changes
    p_strobe_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sens_edge |-> (sens_clk != $past(sens_clk)));
    p_change_has_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_clk != $past(sens_clk)) |-> sens_edge);

    // R7: writes to data-in slots raise no strobe
    p_din_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (req_addr == ADDR_W'(SLOT_D_IN * 4) || req_addr == ADDR_W'(SLOT_A_IN * 4)))
        |=> !sens_edge);

    // R8: outside the window reads as zero
    p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr >= ADDR_W'(WIN_BYTES)) |=> (rsp_valid && rsp_rdata == '0));
endmodule

bind gpio_bridge gpio_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .req_addr         (req_addr),
    .req_wdata        (req_wdata),
    .rsp_valid        (rsp_valid),
    .rsp_rdata        (rsp_rdata),
    .flash_ready      (flash_ready),
    .flash_addr_latch (flash_addr_latch),
    .flash_cmd_latch  (flash_cmd_latch),
    .flash_chip_en    (flash_chip_en),
    .sens_dout        (sens_dout),
    .sens_clk         (sens_clk),
    .sens_edge        (sens_edge)
);

// File: tb/gpio_bridge_tb_top.sv
`timescale 1ns/1ps
module gpio_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        flash_ready = 1'b0;
    logic        flash_addr_latch, flash_cmd_latch, flash_chip_en;
    logic        sens_dout = 1'b0;
    logic        sens_clk, sens_host_bit, sens_edge;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [31:0] mdl [0:22];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;   // 250 MHz

    gpio_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .flash_ready(flash_ready),
        .flash_addr_latch(flash_addr_latch), .flash_cmd_latch(flash_cmd_latch),
        .flash_chip_en(flash_chip_en), .sens_dout(sens_dout), .sens_clk(sens_clk),
        .sens_host_bit(sens_host_bit), .sens_edge(sens_edge)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] v;
        if (a >= 8'h5C || a[1:0] != 2'b00) return '0;
        case (a[7:2])
            6'h01: begin v = mdl[0] & mdl[2]; v[7] = v[7] | flash_ready; end
            6'h11: begin v = mdl[16] & mdl[18]; v[4] = v[4] | sens_dout; end
            default: v = mdl[a[7:2]];
        endcase
        return v;
    endfunction

    // driver: read pushes the expected word into the scoreboard
    task automatic rd(logic [7:0] a, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // driver: write, then check side-band pins against the shadow model
    task automatic wr(logic [7:0] a, logic [31:0] d);
        logic exp_edge;
        bit   valid_slot;
        valid_slot = (a < 8'h5C) && (a[1:0] == 2'b00);
        exp_edge = valid_slot && (a == 8'h40) && (d[1] != mdl[16][1]);
        if (valid_slot && a != 8'h04 && a != 8'h44) mdl[a[7:2]] = d;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 flash ale", {31'b0, flash_addr_latch}, {31'b0, mdl[0][6]});
        chk("R4 flash cle", {31'b0, flash_cmd_latch},  {31'b0, mdl[0][5]});
        chk("R4 flash ce",  {31'b0, flash_chip_en},    {31'b0, mdl[0][4]});
        chk("R6 strobe",    {31'b0, sens_edge},        {31'b0, exp_edge});
        chk("R6 clk level", {31'b0, sens_clk},         {31'b0, mdl[16][1]});
        chk("R6 host bit",  {31'b0, sens_host_bit},    {31'b0, mdl[16][4]});
        @(negedge clk);
        chk("R6 strobe single cycle", {31'b0, sens_edge}, 32'h0);
    endtask

    // monitor: pop and compare as responses arrive
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 23; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 pins after reset",
            {26'b0, flash_addr_latch, flash_cmd_latch, flash_chip_en, sens_clk, sens_host_bit, sens_edge},
            32'h0);
        for (int i = 0; i < 23; i++) rd(8'(i * 4), "R1 register after reset");
        // R2: storage slots
        wr(8'h0C, 32'hDEADBEEF);
        wr(8'h54, 32'h12345678);
        wr(8'h58, 32'hCAFEF00D);
        rd(8'h0C, "R2 storage 0x0C");
        rd(8'h54, "R2 storage 0x54");
        rd(8'h58, "R2 storage 0x58");
        // R3/R4: port A
        wr(8'h08, 32'hFF00FF0F);
        wr(8'h00, 32'hA5A5A5F0);
        flash_ready = 1'b0;
        rd(8'h04, "R3 port A in, ready low");
        flash_ready = 1'b1;
        rd(8'h04, "R3 port A in, ready high");
        wr(8'h00, 32'h00000040);
        wr(8'h00, 32'h00000030);
        rd(8'h04, "R3 port A in after rewrite");
        // R5/R6: port D
        wr(8'h48, 32'h000000FF);
        wr(8'h40, 32'h00000012);   // clock rises
        wr(8'h40, 32'h00000003);   // clock held, host bit drops
        wr(8'h40, 32'h00000000);   // clock falls
        wr(8'h40, 32'h00000002);   // clock rises again
        sens_dout = 1'b1;
        rd(8'h44, "R5 port D in, sdo high");
        sens_dout = 1'b0;
        rd(8'h44, "R5 port D in, sdo low");
        // R7: data-in slots ignore writes
        wr(8'h44, 32'hFFFFFFFD);
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h44, "R7 port D in after write");
        rd(8'h04, "R7 port A in after write");
        rd(8'h40, "R7 port D out untouched");
        // R8: outside window and misaligned
        wr(8'h5C, 32'h11111111);
        wr(8'hFC, 32'h22222222);
        wr(8'h0D, 32'h33333333);
        rd(8'h5C, "R8 read at 0x5C");
        rd(8'hFC, "R8 read at 0xFC");
        rd(8'h0E, "R8 misaligned read");
        rd(8'h00, "R8 no alias into 0x00");
        rd(8'h0C, "R8 storage 0x0C untouched");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule